// File: doc/BRIEF.md
# Lane Frame Alignment Monitor

This block watches the received octet streams of a multi-lane 8b/10b serial link and detects alignment characters that arrive at the wrong place in a frame. Each lane delivers an octet, a control-character flag, a valid strobe and the position of that octet inside its frame. When the link runs with scrambling, the alignment character may only occur on the final octet of a frame. An occurrence anywhere else is counted as an error for that lane.

Every lane has its own saturating error counter, and each counter is compared against a shared programmable threshold. When a lane first reaches the threshold, its sticky flag is set. An interrupt is raised as soon as any lane is flagged and stays high until software clears the monitor. The monitor can also request a link reset, but only when software has enabled that option. By default, recovery is left to software.

The lane inputs are an observation tap, so the monitor accepts an octet on every cycle that its valid strobe is high. It has no ready output and never applies back-pressure to the lane datapath. Configuration and status pins are plain levels.

Top module: `fam_monitor`

## Requirements
- R1: An octet counts as a misplaced alignment character when all of the following hold: it is valid, its control flag is 1, its value is 0xFC, monitoring and scrambling are both enabled, and its frame position differs from `cfg_last_pos`. Each such octet adds one to that lane's count, and the new count is visible after the rising edge that samples it.
- R2: None of these changes a count: 0xFC at position `cfg_last_pos`, 0xFC with the control flag 0, a different control character, or an octet with valid low.
- R3: While `cfg_scr_en` is 0, no octet is counted.
- R4: While `cfg_mon_en` is 0, no octet is counted, and the counts, flags, interrupt and reset request are held at zero from the next edge.
- R5: Each lane's count depends only on that lane's own inputs.
- R6: A count stops at 2^CNT_W-1 (255 by default) and does not wrap.
- R7: A lane's flag `err_flag[l]` is set on the edge where its count becomes greater than or equal to a nonzero `cfg_thresh`, and it stays set. A threshold of 0 never sets a flag.
- R8: `irq` is 1 from the edge on which any lane's flag sets, and it remains 1 until a clear or until monitoring is disabled.
- R9: `link_rst_req` is a one-cycle pulse, issued on the edge where `irq` goes from 0 to 1, and only if `cfg_auto_rst` is 1. With `cfg_auto_rst` at 0, it is never issued.
- R10: A one-cycle `mon_clr` pulse zeroes the counts, flags and interrupt on its edge. It takes priority over a misplaced character on that same edge.
- R11: After reset, all counts, flags, `irq` and `link_rst_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mon_en | input | 1 | Monitoring enable |
| cfg_scr_en | input | 1 | Link uses scrambling |
| cfg_auto_rst | input | 1 | Allow link reset request |
| cfg_thresh | input | CNT_W | Error threshold, 0 = never flag |
| cfg_last_pos | input | POS_W | Octets per frame minus one |
| mon_clr | input | 1 | Clear pulse |
| lane_valid | input | LANES | Per-lane octet valid |
| lane_data | input | 8*LANES | Per-lane octet, lane l at [8l+7:8l] |
| lane_is_k | input | LANES | Per-lane control-character flag |
| lane_pos | input | POS_W*LANES | Per-lane octet position in frame |
| err_cnt | output | CNT_W*LANES | Per-lane error counts |
| err_flag | output | LANES | Per-lane sticky threshold flag |
| irq | output | 1 | Interrupt, level |
| link_rst_req | output | 1 | Link reset request pulse |

## Verification
Every result is registered exactly once. A misplaced character, a clear or a change of enable therefore shows on the counts, flags, `irq` and `link_rst_req` just after the one rising edge that samples it. The bench drives each stimulus on a falling edge, keeps it for one edge, and reads the outputs on the next falling edge. For the reset pulse, it also checks one falling edge later that the pulse has already dropped.

// File: rtl/fam_pkg.sv
package fam_pkg;
  localparam logic [7:0] ALIGN_OCTET = 8'hFC;
endpackage

// File: rtl/fam_lane_cnt.sv
module fam_lane_cnt #(
  parameter int CNT_W = 8,
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             chk_en,
  input  logic             valid,
  input  logic [7:0]       data,
  input  logic             is_k,
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] last_pos,
  input  logic [CNT_W-1:0] thresh,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             flag_nxt
);
  import fam_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             hit;
  logic [CNT_W-1:0] cnt_nxt;

  assign hit = chk_en && valid && is_k && (data == ALIGN_OCTET) && (pos != last_pos);

  always_comb begin
    if (wipe)                        cnt_nxt = '0;
    else if (hit && cnt != CNT_MAX)  cnt_nxt = cnt + 1'b1;
    else                             cnt_nxt = cnt;
    if (wipe) flag_nxt = 1'b0;
    else      flag_nxt = flag || ((thresh != '0) && (cnt_nxt >= thresh));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      flag <= flag_nxt;
    end
  end
endmodule

// File: rtl/fam_irq_ctrl.sv
module fam_irq_ctrl #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_rst,
  input  logic [LANES-1:0] flag_nxt,
  output logic             irq,
  output logic             rst_req
);
  logic any_nxt;
  assign any_nxt = |flag_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      irq     <= any_nxt;
      rst_req <= auto_rst && any_nxt && !irq;
    end
  end
endmodule

// File: rtl/fam_monitor.sv
module fam_monitor #(
  parameter int LANES = 4,
  parameter int CNT_W = 8,
  parameter int POS_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_mon_en,
  input  logic                   cfg_scr_en,
  input  logic                   cfg_auto_rst,
  input  logic [CNT_W-1:0]       cfg_thresh,
  input  logic [POS_W-1:0]       cfg_last_pos,
  input  logic                   mon_clr,
  input  logic [LANES-1:0]       lane_valid,
  input  logic [8*LANES-1:0]     lane_data,
  input  logic [LANES-1:0]       lane_is_k,
  input  logic [POS_W*LANES-1:0] lane_pos,
  output logic [CNT_W*LANES-1:0] err_cnt,
  output logic [LANES-1:0]       err_flag,
  output logic                   irq,
  output logic                   link_rst_req
);
  logic             wipe;
  logic             chk_en;
  logic [LANES-1:0] flag_nxt;

  assign wipe   = mon_clr || !cfg_mon_en;
  assign chk_en = cfg_mon_en && cfg_scr_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fam_lane_cnt #(.CNT_W(CNT_W), .POS_W(POS_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wipe     (wipe),
      .chk_en   (chk_en),
      .valid    (lane_valid[l]),
      .data     (lane_data[8*l +: 8]),
      .is_k     (lane_is_k[l]),
      .pos      (lane_pos[POS_W*l +: POS_W]),
      .last_pos (cfg_last_pos),
      .thresh   (cfg_thresh),
      .cnt      (err_cnt[CNT_W*l +: CNT_W]),
      .flag     (err_flag[l]),
      .flag_nxt (flag_nxt[l])
    );
  end

  fam_irq_ctrl #(.LANES(LANES)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .auto_rst (cfg_auto_rst),
    .flag_nxt (flag_nxt),
    .irq      (irq),
    .rst_req  (link_rst_req)
  );
endmodule

// File: rtl/fam_monitor_chk.sv
module fam_monitor_chk #(
  parameter int LANES = 4,
  parameter int CNT_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_mon_en,
  input logic                   cfg_auto_rst,
  input logic                   mon_clr,
  input logic [CNT_W*LANES-1:0] err_cnt,
  input logic [LANES-1:0]       err_flag,
  input logic                   irq,
  input logic                   link_rst_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R6: a saturated count does not wrap
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt[CNT_W*l +: CNT_W] == CNT_MAX && cfg_mon_en && !mon_clr)
      |=> (err_cnt[CNT_W*l +: CNT_W] == CNT_MAX));
    // R1: counts step by at most one, or go to zero
    assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt[CNT_W*l +: CNT_W] != $past(err_cnt[CNT_W*l +: CNT_W]))
      |-> (err_cnt[CNT_W*l +: CNT_W] == $past(err_cnt[CNT_W*l +: CNT_W]) + 1'b1
           || err_cnt[CNT_W*l +: CNT_W] == '0));
  end

  assert_off_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mon_en |=> (!irq && err_flag == '0 && err_cnt == '0));
  assert_clr_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mon_clr |=> (!irq && err_flag == '0));
  assert_irq_has_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (err_flag != '0));
  assert_req_opt_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst_req |-> ($past(cfg_auto_rst) && $rose(irq)));
  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_rst_req |=> !link_rst_req);
endmodule

bind fam_monitor fam_monitor_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_mon_en   (cfg_mon_en),
  .cfg_auto_rst (cfg_auto_rst),
  .mon_clr      (mon_clr),
  .err_cnt      (err_cnt),
  .err_flag     (err_flag),
  .irq          (irq),
  .link_rst_req (link_rst_req)
);

// File: tb/tb_fam_monitor.sv
module tb_fam_monitor;
  localparam int LANES = 4;
  localparam int CNT_W = 8;
  localparam int POS_W = 8;
  localparam int NVEC  = 10;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   cfg_mon_en = 1'b1;
  logic                   cfg_scr_en = 1'b1;
  logic                   cfg_auto_rst = 1'b0;
  logic [CNT_W-1:0]       cfg_thresh = 8'd100;
  logic [POS_W-1:0]       cfg_last_pos = 8'd3;
  logic                   mon_clr = 1'b0;
  logic [LANES-1:0]       lane_valid = '0;
  logic [8*LANES-1:0]     lane_data = '0;
  logic [LANES-1:0]       lane_is_k = '0;
  logic [POS_W*LANES-1:0] lane_pos = '0;
  logic [CNT_W*LANES-1:0] err_cnt;
  logic [LANES-1:0]       err_flag;
  logic                   irq;
  logic                   link_rst_req;

  int checks = 0;
  int errors = 0;
  int exp_cnt [LANES];

  always #4 clk = ~clk;

  fam_monitor #(.LANES(LANES), .CNT_W(CNT_W), .POS_W(POS_W)) dut (.*);

  // {lane[2], data[8], k, valid, pos[8], inc}
  localparam logic [20:0] VEC [NVEC] = '{
    {2'd0, 8'hFC, 1'b1, 1'b1, 8'd0, 1'b1},  // R1 misplaced
    {2'd0, 8'hFC, 1'b1, 1'b1, 8'd3, 1'b0},  // R2 legal position
    {2'd1, 8'hFC, 1'b1, 1'b1, 8'd1, 1'b1},  // R1 / R5 other lane
    {2'd1, 8'hFC, 1'b0, 1'b1, 8'd1, 1'b0},  // R2 data, not control
    {2'd2, 8'hFC, 1'b1, 1'b0, 8'd2, 1'b0},  // R2 not valid
    {2'd3, 8'hBC, 1'b1, 1'b1, 8'd0, 1'b0},  // R2 other control char
    {2'd3, 8'hFC, 1'b1, 1'b1, 8'd2, 1'b1},  // R1
    {2'd0, 8'hFC, 1'b1, 1'b1, 8'd4, 1'b1},  // R1 beyond frame end
    {2'd2, 8'hFC, 1'b1, 1'b1, 8'd3, 1'b0},  // R2 legal position
    {2'd2, 8'hFC, 1'b1, 1'b1, 8'd0, 1'b1}   // R1
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int l, input logic [7:0] d, input logic k,
                       input logic v, input logic [7:0] p);
    lane_data[8*l +: 8]         = d;
    lane_is_k[l]                = k;
    lane_valid[l]               = v;
    lane_pos[POS_W*l +: POS_W]  = p;
  endtask

  // present one octet for n edges, then read at the following falling edge
  task automatic send(input int l, input logic [7:0] d, input logic k,
                      input logic [7:0] p, input int n);
    @(negedge clk);
    drive(l, d, k, 1'b1, p);
    repeat (n) @(negedge clk);
    lane_valid = '0;
  endtask

  function automatic int cnt_of(input int l);
    return int'(err_cnt[CNT_W*l +: CNT_W]);
  endfunction

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 cnt", int'(err_cnt), 0);
    chk("R11 flag", int'(err_flag), 0);
    chk("R11 irq", int'(irq), 0);
    chk("R11 req", int'(link_rst_req), 0);

    for (int l = 0; l < LANES; l++) exp_cnt[l] = 0;
    // table walk: R1, R2, R5
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      lane_valid = '0;
      drive(int'(VEC[i][20:19]), VEC[i][18:11], VEC[i][10], VEC[i][9], VEC[i][8:1]);
      if (VEC[i][0]) exp_cnt[VEC[i][20:19]]++;
      @(negedge clk);
      lane_valid = '0;
      for (int l = 0; l < LANES; l++)
        chk($sformatf("R1 R2 R5 vec%0d lane%0d", i, l), cnt_of(l), exp_cnt[l]);
    end

    // R10 clear pulse, with clear winning over a misplaced character
    @(negedge clk);
    mon_clr = 1'b1;
    drive(0, 8'hFC, 1'b1, 1'b1, 8'd1);
    @(negedge clk);
    mon_clr = 1'b0;
    lane_valid = '0;
    chk("R10 clr cnt", int'(err_cnt), 0);

    // R3 scrambling off
    cfg_scr_en = 1'b0;
    send(1, 8'hFC, 1'b1, 8'd0, 3);
    chk("R3 no count", cnt_of(1), 0);
    cfg_scr_en = 1'b1;

    // R7 / R8 threshold, no auto reset
    cfg_thresh = 8'd3;
    send(2, 8'hFC, 1'b1, 8'd1, 2);
    chk("R7 below thresh", int'(err_flag[2]), 0);
    chk("R8 irq low", int'(irq), 0);
    send(2, 8'hFC, 1'b1, 8'd1, 1);
    chk("R7 flag set", int'(err_flag[2]), 1);
    chk("R8 irq set", int'(irq), 1);
    chk("R9 no req when off", int'(link_rst_req), 0);
    repeat (3) @(negedge clk);
    chk("R8 irq held", int'(irq), 1);
    chk("R7 flag sticky", int'(err_flag[2]), 1);
    // R10 clear drops flags and irq
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    chk("R10 irq clear", int'(irq), 0);
    chk("R10 flag clear", int'(err_flag), 0);

    // R9 auto reset pulse
    cfg_auto_rst = 1'b1;
    send(3, 8'hFC, 1'b1, 8'd0, 3);
    chk("R9 req pulse", int'(link_rst_req), 1);
    send(0, 8'hFC, 1'b1, 8'd0, 3);
    chk("R9 pulse one cycle", int'(link_rst_req), 0);
    chk("R7 second lane flag", int'(err_flag), 4'b1001);

    // R4 monitoring disabled
    cfg_mon_en = 1'b0;
    @(negedge clk);
    chk("R4 irq off", int'(irq), 0);
    chk("R4 cnt off", int'(err_cnt), 0);
    send(1, 8'hFC, 1'b1, 8'd0, 2);
    chk("R4 no count", cnt_of(1), 0);
    cfg_mon_en = 1'b1;
    cfg_auto_rst = 1'b0;

    // R6 saturation, R7 threshold 0 never flags
    cfg_thresh = 8'd0;
    send(1, 8'hFC, 1'b1, 8'd2, 300);
    chk("R6 saturate", cnt_of(1), 255);
    chk("R7 thresh zero", int'(err_flag[1]), 0);
    chk("R8 no irq", int'(irq), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule